// File: doc/BRIEF.md
# Data lane HS burst transmitter

This block sequences the line of one serial data lane through a single high-speed burst. While the lane rests in the stop state, it waits for a burst request together with a flag from the clock lane saying that the clock has run long enough ahead of the data. It then signals the LP-to-HS entry, drives the HS-0 lead-in and a fixed sync byte. Next it serializes the payload bytes taken from a valid/ready byte stream, drives a trail at the inverse of the final bit, and returns to LP-11 for an exit interval.

One clock cycle is one unit interval (UI): the serial output moves one bit per cycle. Every phase length comes in as a cycle count on its own input. The integrating logic picks counts that meet the analog limits for its HS clock period. Those limits are:

- prepare: 40 ns + 4 UI up to 85 ns + 6 UI
- trail: at least the larger of 8 UI and 60 ns + 4 UI
- exit: at least 100 ns
- trail start to LP-11: at most 105 ns + 12 UI

The counts should stay stable during a burst. The line state appears as a two-bit low-power level pair plus an HS-enable flag and the HS bit.

Top module: `dlane_hs_tx`

## Requirements
- R1: Out of reset, and after a burst has ended, the lane sits in stop: lp_o = 2'b11, hs_en_o = 0, ready_o = 0.
- R2: A burst starts only from stop, on a cycle where req_i and clk_ready_i are both 1. With clk_ready_i low the lane stays in stop. A request raised during a burst has no effect on that burst.
- R3: The first cycle after the start condition begins the entry. lp_o = 2'b01 for max(lpx_cyc_i,1) cycles, then lp_o = 2'b00 for max(prep_cyc_i,1) cycles, with hs_en_o = 0 throughout. Whenever hs_en_o = 1, lp_o reads 2'b00.
- R4: Next, hs_en_o = 1 with hs_bit_o = 0 for max(zero_cyc_i,1) cycles.
- R5: The byte 8'b00011101 follows, one bit per cycle, bit 0 first.
- R6: Payload bytes follow the sync byte back to back, bit 0 first, one bit per cycle, with no idle cycles between bytes.
- R7: ready_o is 1 only in the final bit cycle of the sync byte and in the final bit cycle of each payload byte not marked last. A byte is taken on a rising edge where ready_o and valid_i are both 1.
- R8: The burst's payload ends after a byte taken with last_i = 1. It also ends when valid_i is 0 in a cycle where ready_o is 1, and then the bits already sent end the burst (only the sync byte when no byte was taken).
- R9: The trail follows directly. hs_en_o = 1 and hs_bit_o holds the inverse of the last bit sent, for max(trail_cyc_i,1) cycles.
- R10: The exit follows directly. hs_en_o = 0 and lp_o = 2'b11 for max(exit_cyc_i,1) cycles, and the lane then returns to stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one UI per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Burst request |
| clk_ready_i | input | 1 | Clock lane has completed its lead interval |
| lpx_cyc_i | input | CW | LP-01 request length in cycles |
| prep_cyc_i | input | CW | LP-00 prepare length in cycles |
| zero_cyc_i | input | CW | HS-0 lead-in length in cycles |
| trail_cyc_i | input | CW | Trail length in cycles |
| exit_cyc_i | input | CW | LP-11 exit length in cycles |
| data_i | input | 8 | Payload byte |
| valid_i | input | 1 | Payload byte present |
| last_i | input | 1 | Payload byte is the final one of the burst |
| ready_o | output | 1 | Byte is taken at the next rising edge if valid_i |
| lp_o | output | 2 | Low-power level pair {P,N} |
| hs_en_o | output | 1 | Lane is in high-speed drive |
| hs_bit_o | output | 1 | High-speed serial bit |

## Verification
A wrong phase state or a wrong phase counter shows at the ports in the cycle the phase should have changed. The low-power pair or the HS flag then differs, so the bench compares every output in every cycle of the burst against a timeline built from the counts. A shift register or bit index fault shows as a wrong bit within eight cycles, or as ready_o pulsing in the wrong cycle. A wrong trail level shows on the first trail cycle. Fetch and end-of-stream faults move the trail and shift every later cycle, so they fail many checks at once.

// File: rtl/dlane_hs_pkg.sv
package dlane_hs_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam logic [7:0]  SYNC_BYTE = 8'b0001_1101;
  localparam logic [1:0]  LP11      = 2'b11;
  localparam logic [1:0]  LP01      = 2'b01;
  localparam logic [1:0]  LP00      = 2'b00;

  typedef enum logic [2:0] {
    PH_STOP, PH_REQ, PH_PREP, PH_ZERO, PH_SYNC, PH_DATA, PH_TRAIL, PH_EXIT
  } phase_e;
endpackage

// File: rtl/dlane_phase_timer.sv
module dlane_phase_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] val_i,
  output logic          done_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  // a load of 0 or 1 both give a one-cycle phase
  assign done_o = (cnt_q <= CW'(1));
endmodule

// File: rtl/dlane_byte_ser.sv
module dlane_byte_ser #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         shift_i,
  output logic         bit_o,
  output logic         at_end_o
);
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0]  sh_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      sh_q  <= val_i;
      idx_q <= '0;
    end else if (shift_i) begin
      sh_q  <= sh_q >> 1;
      idx_q <= idx_q + IW'(1);
    end
  end

  assign bit_o    = sh_q[0];
  assign at_end_o = (idx_q == IW'(W - 1));
endmodule

// File: rtl/dlane_hs_tx.sv
module dlane_hs_tx
  import dlane_hs_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          clk_ready_i,
  input  logic [CW-1:0] lpx_cyc_i,
  input  logic [CW-1:0] prep_cyc_i,
  input  logic [CW-1:0] zero_cyc_i,
  input  logic [CW-1:0] trail_cyc_i,
  input  logic [CW-1:0] exit_cyc_i,
  input  logic [7:0]    data_i,
  input  logic          valid_i,
  input  logic          last_i,
  output logic          ready_o,
  output logic [1:0]    lp_o,
  output logic          hs_en_o,
  output logic          hs_bit_o
);
  phase_e        st_q, st_d;
  logic          last_q, last_d;
  logic          lvl_q, lvl_d;
  logic          tmr_load, tmr_done;
  logic [CW-1:0] tmr_val;
  logic          ser_load, ser_shift, ser_bit, ser_end;
  logic [7:0]    ser_val;
  logic          fetch;

  dlane_phase_timer #(.CW(CW)) u_tmr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .done_o (tmr_done)
  );

  dlane_byte_ser #(.W(BYTE_W)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (ser_load),
    .val_i    (ser_val),
    .shift_i  (ser_shift),
    .bit_o    (ser_bit),
    .at_end_o (ser_end)
  );

  assign ready_o = ser_end && ((st_q == PH_SYNC) || (st_q == PH_DATA && !last_q));
  assign fetch   = ready_o && valid_i;

  always_comb begin
    st_d      = st_q;
    last_d    = last_q;
    lvl_d     = lvl_q;
    tmr_load  = 1'b0;
    tmr_val   = lpx_cyc_i;
    ser_load  = 1'b0;
    ser_val   = SYNC_BYTE;
    ser_shift = 1'b0;
    unique case (st_q)
      PH_STOP: if (req_i && clk_ready_i) begin
        st_d     = PH_REQ;
        tmr_load = 1'b1;
        tmr_val  = lpx_cyc_i;
      end
      PH_REQ: if (tmr_done) begin
        st_d     = PH_PREP;
        tmr_load = 1'b1;
        tmr_val  = prep_cyc_i;
      end
      PH_PREP: if (tmr_done) begin
        st_d     = PH_ZERO;
        tmr_load = 1'b1;
        tmr_val  = zero_cyc_i;
      end
      PH_ZERO: if (tmr_done) begin
        st_d     = PH_SYNC;
        ser_load = 1'b1;
        ser_val  = SYNC_BYTE;
      end
      PH_SYNC, PH_DATA: begin
        if (!ser_end) begin
          ser_shift = 1'b1;
        end else if (fetch) begin
          st_d     = PH_DATA;
          ser_load = 1'b1;
          ser_val  = data_i;
          last_d   = last_i;
        end else begin
          // payload over: trail mirrors the bit now on the line
          st_d     = PH_TRAIL;
          lvl_d    = ~ser_bit;
          tmr_load = 1'b1;
          tmr_val  = trail_cyc_i;
        end
      end
      PH_TRAIL: if (tmr_done) begin
        st_d     = PH_EXIT;
        tmr_load = 1'b1;
        tmr_val  = exit_cyc_i;
      end
      PH_EXIT: if (tmr_done) st_d = PH_STOP;
      default: st_d = PH_STOP;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PH_STOP;
      last_q <= 1'b0;
      lvl_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      last_q <= last_d;
      lvl_q  <= lvl_d;
    end
  end

  always_comb begin
    lp_o     = LP00;
    hs_en_o  = 1'b0;
    hs_bit_o = 1'b0;
    unique case (st_q)
      PH_STOP, PH_EXIT: lp_o = LP11;
      PH_REQ:           lp_o = LP01;
      PH_PREP:          lp_o = LP00;
      PH_ZERO:          hs_en_o = 1'b1;
      PH_SYNC, PH_DATA: begin
        hs_en_o  = 1'b1;
        hs_bit_o = ser_bit;
      end
      PH_TRAIL: begin
        hs_en_o  = 1'b1;
        hs_bit_o = lvl_q;
      end
      default: lp_o = LP11;
    endcase
  end
endmodule

// File: rtl/dlane_hs_tx_chk.sv
module dlane_hs_tx_chk
  import dlane_hs_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_i,
  input logic       clk_ready_i,
  input logic       ready_o,
  input logic [1:0] lp_o,
  input logic       hs_en_o,
  input logic       hs_bit_o,
  input phase_e     st_i
);
  a_r2_stop_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == PH_STOP && !(req_i && clk_ready_i)) |=> (st_i == PH_STOP));

  a_r3_lp01_then_lp00: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_o == LP01 && !hs_en_o) |=> (!hs_en_o && (lp_o == LP01 || lp_o == LP00)));

  a_r3_hs_quiet_lp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_en_o |-> (lp_o == LP00));

  a_r4_hs_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hs_en_o) |-> ($past(lp_o) == LP00 && !hs_bit_o));

  a_r7_ready_in_hs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (hs_en_o && (st_i == PH_SYNC || st_i == PH_DATA)));

  a_r9_trail_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == PH_TRAIL) |=> (st_i != PH_TRAIL || $stable(hs_bit_o)));

  a_r10_exit_lp11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_en_o) |-> (lp_o == LP11));
endmodule

bind dlane_hs_tx dlane_hs_tx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .clk_ready_i (clk_ready_i),
  .ready_o     (ready_o),
  .lp_o        (lp_o),
  .hs_en_o     (hs_en_o),
  .hs_bit_o    (hs_bit_o),
  .st_i        (st_q)
);

// File: tb/dlane_hs_tx_tb.sv
module dlane_hs_tx_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CW = 8;
  localparam logic [7:0] SYNC_B = 8'b0001_1101;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, clk_ready_i = 1'b0;
  logic [CW-1:0] lpx_cyc_i = '0, prep_cyc_i = '0, zero_cyc_i = '0;
  logic [CW-1:0] trail_cyc_i = '0, exit_cyc_i = '0;
  logic [7:0]    data_i = '0;
  logic          valid_i = 1'b0, last_i = 1'b0;
  logic          ready_o, hs_en_o, hs_bit_o;
  logic [1:0]    lp_o;

  dlane_hs_tx #(.CW(CW)) u_dut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_run = 0, n_fail = 0;
  logic [7:0] pay [8];
  int k, n_b, drop;
  bit pend;

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  function automatic int mx1(int v);
    return (v < 1) ? 1 : v;
  endfunction

  task automatic chk(string tag, logic [4:0] act, logic [4:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s {rdy,hs,lp,bit} act=%b exp=%b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] obs();
    return {ready_o, hs_en_o, lp_o, hs_bit_o};
  endfunction

  // byte source, updated away from the clock edge
  task automatic drive_stream();
    if (pend) k++;
    valid_i = (k < n_b) && (k != drop);
    data_i  = (k < 8) ? pay[k] : 8'h00;
    last_i  = (k == n_b - 1);
    pend    = ready_o && valid_i;
  endtask

  task automatic run_burst(int nb, int lpx, int prep, int zero, int trail, int ext,
                           int drp, bit wait_clk, bit mid_req);
    int o_prep, o_zero, o_sync, o_pay, o_trail, o_exit, o_end, neff;
    logic lastbit;
    @(negedge clk_i);
    n_b = nb; drop = drp; k = 0; pend = 1'b0;
    for (int i = 0; i < 8; i++) pay[i] = 8'($urandom);
    lpx_cyc_i = CW'(lpx); prep_cyc_i = CW'(prep); zero_cyc_i = CW'(zero);
    trail_cyc_i = CW'(trail); exit_cyc_i = CW'(ext);
    req_i = 1'b1;
    clk_ready_i = !wait_clk;
    drive_stream();
    if (wait_clk) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk_i);
        chk("R2 held off by clock lane", obs(), 5'b0_0_11_0);
      end
      clk_ready_i = 1'b1;
    end
    neff    = (drp < nb) ? drp : nb;
    o_prep  = mx1(lpx);
    o_zero  = o_prep + mx1(prep);
    o_sync  = o_zero + mx1(zero);
    o_pay   = o_sync + 8;
    o_trail = o_pay + 8 * neff;
    o_exit  = o_trail + mx1(trail);
    o_end   = o_exit + mx1(ext);
    lastbit = (neff == 0) ? SYNC_B[7] : pay[neff-1][7];
    for (int c = 0; c < o_end + 3; c++) begin
      @(negedge clk_i);
      if (c < o_prep)       chk("R3 lp01", obs(), 5'b0_0_01_0);
      else if (c < o_zero)  chk("R3 lp00", obs(), 5'b0_0_00_0);
      else if (c < o_sync)  chk("R4 hs0", obs(), 5'b0_1_00_0);
      else if (c < o_pay)   chk("R5 sync", obs(),
                                {(c - o_sync) == 7, 1'b1, 2'b00, SYNC_B[c - o_sync]});
      else if (c < o_trail) begin
        int j = (c - o_pay) / 8;
        int b = (c - o_pay) % 8;
        chk((b == 7) ? "R7 R6 fetch" : "R6 payload", obs(),
            {(b == 7) && (j != nb - 1), 1'b1, 2'b00, pay[j][b]});
      end
      else if (c < o_exit)  chk((neff < nb) ? "R8 R9 trail" : "R9 trail", obs(),
                                {2'b01, 2'b00, ~lastbit});
      else if (c < o_end)   chk("R10 exit", obs(), 5'b0_0_11_0);
      else                  chk("R1 back to stop", obs(), 5'b0_0_11_0);
      req_i = mid_req && (c == o_zero);
      drive_stream();
    end
    valid_i = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    #12;
    chk("R1 in reset", obs(), 5'b0_0_11_0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset", obs(), 5'b0_0_11_0);
    // directed corners
    run_burst(1, 1, 1, 1, 1, 1, 99, 1'b1, 1'b0);
    run_burst(2, 0, 0, 0, 0, 0, 99, 1'b0, 1'b0);
    run_burst(3, 2, 3, 4, 5, 3, 0, 1'b0, 1'b0);   // R8 no byte taken
    run_burst(4, 3, 2, 2, 3, 2, 2, 1'b0, 1'b0);   // R8 stall mid-stream
    run_burst(3, 2, 2, 3, 4, 4, 99, 1'b0, 1'b1);  // R2 request during burst
    for (int r = 0; r < 25; r++) begin
      int nb = $urandom_range(1, 6);
      int dp = ($urandom_range(0, 3) == 0) ? $urandom_range(0, nb - 1) : 99;
      run_burst(nb, $urandom_range(0, 5), $urandom_range(0, 5), $urandom_range(0, 7),
                $urandom_range(0, 7), $urandom_range(0, 6), dp,
                bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)));
    end
    report();
    $finish;
  end
endmodule